// File: doc/BRIEF.md
# Signed Byte Load Decode-Execute Unit

This unit takes one 32-bit instruction word and, if the word is an immediate-offset load of a signed byte, carries the load out from start to finish. It accepts words from two instruction sets. The fixed-width set has one encoding with an 8-bit split immediate and P/U/W addressing bits. The mixed-width set has two 32-bit encodings: one with a 12-bit add-only offset, and one with an 8-bit offset plus P/U/W bits. A select input tells the unit which set the word belongs to.

The unit reads the base register through a combinational read port. It then sorts the word into one of eight outcomes: an executed load, a skipped load, an unpredictable case, an undefined case, no match, or a redirect to one of three related instructions. For an executed load it holds a one-byte request on a memory port until the response arrives. It then writes the sign-extended byte to the destination register and, when writeback applies, the offset address to the base register. Every accepted word retires with a single `done` pulse that carries its outcome code.

Top module: `sbyte_load_unit`

## Requirements
- R1: Fixed-width form (mixed_isa=0) matches cond[31:28]!=1111, [27:25]=000, [22]=1, [20]=1, [7:4]=1101. Its offset is {insn[11:8],insn[3:0]} zero-extended. Bit 24 (P) selects pre-indexing, bit 23 (U) selects add, and writeback happens when P=0 or bit 21 (W)=1.
- R2: First mixed form (mixed_isa=1, insn[31:20]=0xF99) uses insn[11:0] zero-extended as the offset. It always pre-indexes, always adds, and never writes back.
- R3: Second mixed form (mixed_isa=1, insn[31:20]=0xF91, insn[11]=1) uses insn[7:0] zero-extended as the offset. P, U and W are bits 10, 9 and 8, and writeback happens exactly when W=1.
- R4: Redirects retire with no access. The outcome codes are 5 for the literal form, 6 for the unprivileged load and 7 for the preload hint.
  - Code 7 applies to the first mixed form with Rt=1111, and to the second mixed form with Rt=1111 and P=1,U=0,W=0.
  - Otherwise, code 5 applies to any form with Rn (insn[19:16])=1111.
  - Otherwise, code 6 applies to the fixed form with P=0,W=1, and to the second mixed form with P=1,U=1,W=0.
- R5: The second mixed form with P=0,W=0 retires as undefined (code 3). A word that matches no form for the selected set retires as no-match (code 4).
- R6: These cases retire as code 2 with unpred_flag high and no memory access or register write:
  - fixed form with Rt (insn[15:12])=15;
  - second mixed form with Rt=15 and W=1;
  - any form with writeback and Rn=Rt.
- R7: When cond_pass is low, a word not already redirected, undefined or unmatched retires as skipped (code 1), with no access and no write.
- R8: The offset address is base+offset when adding and base-offset otherwise, modulo 2^32. The memory address is the offset address when pre-indexed and the base when post-indexed.
- R9: One cycle after the edge that takes the response, dst_we pulses with the byte sign-extended to 32 bits. base_we pulses in the same cycle with the offset address, but only when writeback applies. done is high in that cycle with outcome 0.
- R10: mem_req rises the cycle after an executed load is accepted. It stays high with a stable mem_addr until mem_rsp_valid is seen. A response while no request is open has no effect.
- R11: A word that is not executed retires with done high for exactly one cycle, one cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction word valid; taken when busy is low |
| insn | input | 32 | Instruction word |
| mixed_isa | input | 1 | 0: fixed-width set, 1: mixed-width set |
| cond_pass | input | 1 | Condition check result for this word |
| busy | output | 1 | Unit holds an instruction |
| rd_sel | output | 4 | Base register index for the read port |
| rd_val | input | 32 | Base register value |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 32 | Byte read address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 8 | Read response byte |
| dst_we | output | 1 | Destination register write |
| dst_sel | output | 4 | Destination register index |
| dst_data | output | 32 | Sign-extended byte |
| base_we | output | 1 | Base register writeback |
| wb_sel | output | 4 | Base register index for writeback |
| wb_data | output | 32 | Offset address written back |
| done | output | 1 | Instruction retires this cycle |
| outcome | output | 3 | Outcome code, valid with done |
| unpred_flag | output | 1 | Retired as unpredictable |

## Verification
A word that is not executed shows done and its outcome one cycle after the edge that accepts it, and the next cycle must be quiet. An executed load raises mem_req in that same first cycle and keeps it up through any number of wait cycles. Both register writes then appear one cycle after the edge that samples the response. The bench drives every input on the falling edge and predicts each cycle's outputs before that cycle starts. It compares all outputs on the next falling edge, so each comparison sees the value at the exact cycle in which it is due.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 4;

  typedef enum logic [2:0] {
    OUT_LOAD    = 3'd0,
    OUT_SKIP    = 3'd1,
    OUT_UNPRED  = 3'd2,
    OUT_UNDEF   = 3'd3,
    OUT_NOMATCH = 3'd4,
    OUT_LIT     = 3'd5,
    OUT_UNPRIV  = 3'd6,
    OUT_PRELOAD = 3'd7
  } outcome_e;

  typedef struct packed {
    logic [IDX_W-1:0]  rn;
    logic [IDX_W-1:0]  rt;
    logic [DATA_W-1:0] imm;
    logic              index;
    logic              add;
    logic              wback;
  } acc_t;

  function automatic logic [DATA_W-1:0] offset_of(input logic [DATA_W-1:0] base,
                                                  input logic [DATA_W-1:0] imm,
                                                  input logic add);
    return add ? (base + imm) : (base - imm);
  endfunction

  function automatic logic [DATA_W-1:0] pick_addr(input logic [DATA_W-1:0] base,
                                                  input logic [DATA_W-1:0] off,
                                                  input logic index);
    return index ? off : base;
  endfunction

  function automatic logic [DATA_W-1:0] sext_byte(input logic [BYTE_W-1:0] b);
    return {{(DATA_W-BYTE_W){b[BYTE_W-1]}}, b};
  endfunction
endpackage

// File: rtl/sbl_decode.sv
module sbl_decode
  import sbl_pkg::*;
(
  input  logic [31:0] insn,
  input  logic        mixed_isa,
  input  logic        cond_pass,
  output outcome_e    kind,
  output acc_t        acc
);
  logic fx_hit, m1_hit, m2_hit, any_hit;
  logic p_b, u_b, w_b;
  logic rn15, rt15, same_reg;

  assign fx_hit = !mixed_isa && (insn[31:28] != 4'hF) && (insn[27:25] == 3'b000)
                  && insn[22] && insn[20] && (insn[7:4] == 4'b1101);
  assign m1_hit = mixed_isa && (insn[31:20] == 12'hF99);
  assign m2_hit = mixed_isa && (insn[31:20] == 12'hF91) && insn[11];
  assign any_hit = fx_hit || m1_hit || m2_hit;

  always_comb begin
    if (m1_hit) begin
      p_b = 1'b1; u_b = 1'b1; w_b = 1'b0;
    end else if (m2_hit) begin
      p_b = insn[10]; u_b = insn[9]; w_b = insn[8];
    end else begin
      p_b = insn[24]; u_b = insn[23]; w_b = insn[21];
    end
  end

  always_comb begin
    acc.rn    = insn[19:16];
    acc.rt    = insn[15:12];
    acc.index = p_b;
    acc.add   = u_b;
    if (m1_hit) begin
      acc.imm   = {{(DATA_W-12){1'b0}}, insn[11:0]};
      acc.wback = 1'b0;
    end else if (m2_hit) begin
      acc.imm   = {{(DATA_W-8){1'b0}}, insn[7:0]};
      acc.wback = w_b;
    end else begin
      acc.imm   = {{(DATA_W-8){1'b0}}, insn[11:8], insn[3:0]};
      acc.wback = !p_b || w_b;
    end
  end

  assign rn15     = (insn[19:16] == 4'hF);
  assign rt15     = (insn[15:12] == 4'hF);
  assign same_reg = (insn[19:16] == insn[15:12]);

  // Priority: unmatched, redirects, undefined, condition, unpredictable.
  always_comb begin
    if (!any_hit)                                         kind = OUT_NOMATCH;
    else if (m1_hit && rt15)                              kind = OUT_PRELOAD;
    else if (m2_hit && rt15 && p_b && !u_b && !w_b)       kind = OUT_PRELOAD;
    else if (rn15)                                        kind = OUT_LIT;
    else if (fx_hit && !p_b && w_b)                       kind = OUT_UNPRIV;
    else if (m2_hit && p_b && u_b && !w_b)                kind = OUT_UNPRIV;
    else if (m2_hit && !p_b && !w_b)                      kind = OUT_UNDEF;
    else if (!cond_pass)                                  kind = OUT_SKIP;
    else if ((fx_hit && rt15) || (m2_hit && rt15 && w_b) || (acc.wback && same_reg))
                                                          kind = OUT_UNPRED;
    else                                                  kind = OUT_LOAD;
  end
endmodule

// File: rtl/sbl_agen.sv
module sbl_agen
  import sbl_pkg::*;
(
  input  logic [DATA_W-1:0] base,
  input  acc_t              acc,
  output logic [DATA_W-1:0] off_addr,
  output logic [DATA_W-1:0] acc_addr
);
  assign off_addr = offset_of(base, acc.imm, acc.add);
  assign acc_addr = pick_addr(base, off_addr, acc.index);
endmodule

// File: rtl/sbl_ctrl.sv
module sbl_ctrl
  import sbl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  outcome_e          kind,
  input  logic [IDX_W-1:0]  rn,
  input  logic [IDX_W-1:0]  rt,
  input  logic              wback,
  input  logic [DATA_W-1:0] off_addr,
  input  logic [DATA_W-1:0] acc_addr,
  output logic              busy,
  output logic              mem_req,
  output logic [DATA_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [BYTE_W-1:0] mem_rsp_data,
  output logic              dst_we,
  output logic [IDX_W-1:0]  dst_sel,
  output logic [DATA_W-1:0] dst_data,
  output logic              base_we,
  output logic [IDX_W-1:0]  wb_sel,
  output logic [DATA_W-1:0] wb_data,
  output logic              done,
  output logic [2:0]        outcome,
  output logic              unpred_flag
);
  typedef enum logic [1:0] {ST_IDLE, ST_MEM, ST_WB, ST_RET} st_e;

  st_e               state;
  outcome_e          out_q;
  logic [DATA_W-1:0] addr_q, off_q;
  logic [IDX_W-1:0]  rn_q, rt_q;
  logic              wb_q;
  logic [BYTE_W-1:0] byte_q;

  // Named events for the checks below.
  logic accept, go_mem, rsp_take;
  assign accept   = start && (state == ST_IDLE);
  assign go_mem   = accept && (kind == OUT_LOAD);
  assign rsp_take = (state == ST_MEM) && mem_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      out_q  <= OUT_NOMATCH;
      addr_q <= '0;
      off_q  <= '0;
      rn_q   <= '0;
      rt_q   <= '0;
      wb_q   <= 1'b0;
      byte_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          out_q  <= kind;
          addr_q <= acc_addr;
          off_q  <= off_addr;
          rn_q   <= rn;
          rt_q   <= rt;
          wb_q   <= wback;
          state  <= go_mem ? ST_MEM : ST_RET;
        end
        ST_MEM: if (rsp_take) begin
          byte_q <= mem_rsp_data;
          state  <= ST_WB;
        end
        ST_WB:   state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state != ST_IDLE);
  assign mem_req     = (state == ST_MEM);
  assign mem_addr    = addr_q;
  assign dst_we      = (state == ST_WB);
  assign dst_sel     = rt_q;
  assign dst_data    = sext_byte(byte_q);
  assign base_we     = (state == ST_WB) && wb_q;
  assign wb_sel      = rn_q;
  assign wb_data     = off_q;
  assign done        = (state == ST_WB) || (state == ST_RET);
  assign outcome     = out_q;
  assign unpred_flag = (state == ST_RET) && (out_q == OUT_UNPRED);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr)));

  p_wr_after_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> $past(mem_req && mem_rsp_valid));

  p_wr_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rsp_valid) |=> (dst_we && dst_data == sext_byte($past(mem_rsp_data))));

  p_base_with_dst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |-> (dst_we && done && outcome == OUT_LOAD));

  p_quiet_nonload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && outcome != OUT_LOAD) |-> (!dst_we && !base_we && !mem_req));

  p_single_retire_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_flag_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unpred_flag |-> (done && outcome == OUT_UNPRED));
endmodule

// File: rtl/sbyte_load_unit.sv
module sbyte_load_unit
  import sbl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] insn,
  input  logic        mixed_isa,
  input  logic        cond_pass,
  output logic        busy,
  output logic [3:0]  rd_sel,
  input  logic [31:0] rd_val,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rsp_valid,
  input  logic [7:0]  mem_rsp_data,
  output logic        dst_we,
  output logic [3:0]  dst_sel,
  output logic [31:0] dst_data,
  output logic        base_we,
  output logic [3:0]  wb_sel,
  output logic [31:0] wb_data,
  output logic        done,
  output logic [2:0]  outcome,
  output logic        unpred_flag
);
  outcome_e          dec_kind;
  acc_t              dec_acc;
  logic [DATA_W-1:0] off_addr, acc_addr;

  sbl_decode u_dec (
    .insn      (insn),
    .mixed_isa (mixed_isa),
    .cond_pass (cond_pass),
    .kind      (dec_kind),
    .acc       (dec_acc)
  );

  assign rd_sel = dec_acc.rn;

  sbl_agen u_agen (
    .base     (rd_val),
    .acc      (dec_acc),
    .off_addr (off_addr),
    .acc_addr (acc_addr)
  );

  sbl_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .kind          (dec_kind),
    .rn            (dec_acc.rn),
    .rt            (dec_acc.rt),
    .wback         (dec_acc.wback),
    .off_addr      (off_addr),
    .acc_addr      (acc_addr),
    .busy          (busy),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .dst_we        (dst_we),
    .dst_sel       (dst_sel),
    .dst_data      (dst_data),
    .base_we       (base_we),
    .wb_sel        (wb_sel),
    .wb_data       (wb_data),
    .done          (done),
    .outcome       (outcome),
    .unpred_flag   (unpred_flag)
  );

  p_no_self_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_we && base_we) |-> (dst_sel != wb_sel));

  p_req_needs_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
endmodule

// File: tb/sbyte_load_unit_test.sv
module sbyte_load_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] insn = '0;
  logic        mixed_isa = 1'b0;
  logic        cond_pass = 1'b1;
  logic        busy;
  logic [3:0]  rd_sel;
  logic [31:0] rd_val;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = '0;
  logic        dst_we, base_we, done, unpred_flag;
  logic [3:0]  dst_sel, wb_sel;
  logic [31:0] dst_data, wb_data;
  logic [2:0]  outcome;

  logic [31:0] regs [16];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rd_val = regs[rd_sel];

  sbyte_load_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .mixed_isa(mixed_isa),
    .cond_pass(cond_pass), .busy(busy), .rd_sel(rd_sel), .rd_val(rd_val),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .dst_we(dst_we), .dst_sel(dst_sel),
    .dst_data(dst_data), .base_we(base_we), .wb_sel(wb_sel), .wb_data(wb_data),
    .done(done), .outcome(outcome), .unpred_flag(unpred_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fx(input logic [3:0] c, input bit p, input bit u, input bit w,
                                     input logic [3:0] rn, input logic [3:0] rt, input logic [7:0] imm);
    return {c, 3'b000, p, u, 1'b1, w, 1'b1, rn, rt, imm[7:4], 4'b1101, imm[3:0]};
  endfunction
  function automatic logic [31:0] mx1(input logic [3:0] rn, input logic [3:0] rt, input logic [11:0] imm);
    return {12'hF99, rn, rt, imm};
  endfunction
  function automatic logic [31:0] mx2(input logic [3:0] rn, input logic [3:0] rt, input bit p,
                                      input bit u, input bit w, input logic [7:0] imm);
    return {12'hF91, rn, rt, 1'b1, p, u, w, imm};
  endfunction

  // Behavioural reference: outcome code, address, writeback and offset address.
  task automatic predict(input logic [31:0] w, input bit m, input bit cp, output int code,
                         output logic [31:0] addr, output bit wb, output logic [31:0] off);
    int rn, rt, imm;
    bit p, u, wf, f0, f1, f2;
    logic [31:0] base;
    rn = int'(w[19:16]); rt = int'(w[15:12]);
    f0 = !m && w[31:28] != 4'hF && w[27:25] == 3'b000 && w[22] && w[20] && w[7:4] == 4'hD;
    f1 = m && w[31:20] == 12'hF99;
    f2 = m && w[31:20] == 12'hF91 && w[11];
    p = 1; u = 1; wf = 0; wb = 0; imm = 0;
    if (f0) begin p = w[24]; u = w[23]; wf = w[21]; wb = !p || wf; imm = int'(w[11:8]) * 16 + int'(w[3:0]); end
    if (f1) imm = int'(w[11:0]);
    if (f2) begin p = w[10]; u = w[9]; wf = w[8]; wb = wf; imm = int'(w[7:0]); end
    base = regs[rn];
    off  = u ? base + 32'(imm) : base - 32'(imm);
    addr = p ? off : base;
    if (!(f0 || f1 || f2))                      code = 4;
    else if (f1 && rt == 15)                    code = 7;
    else if (f2 && rt == 15 && p && !u && !wf)  code = 7;
    else if (rn == 15)                          code = 5;
    else if (f0 && !p && wf)                    code = 6;
    else if (f2 && p && u && !wf)               code = 6;
    else if (f2 && !p && !wf)                   code = 3;
    else if (!cp)                               code = 1;
    else if ((f0 && rt == 15) || (f2 && rt == 15 && wf) || (wb && rn == rt)) code = 2;
    else                                        code = 0;
  endtask

  task automatic run(input string rq, input logic [31:0] w, input bit m, input bit cp,
                     input int lat, input logic [7:0] b);
    int code;
    logic [31:0] addr, off;
    bit wb;
    predict(w, m, cp, code, addr, wb, off);
    @(negedge clk);
    insn = w; mixed_isa = m; cond_pass = cp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (code != 0) begin
      chk({rq, " done"}, 32'(done), 32'd1);
      chk({rq, " outcome"}, 32'(outcome), 32'(code));
      chk({rq, " unpred_flag"}, 32'(unpred_flag), 32'(code == 2));
      chk({rq, " no access"}, {29'd0, mem_req, dst_we, base_we}, 32'd0);
      @(negedge clk);
      chk({rq, " R11 single done"}, 32'(done), 32'd0);
    end else begin
      for (int i = 0; i < lat; i++) begin
        chk({rq, " R10 req held"}, 32'(mem_req), 32'd1);
        chk({rq, " R8 addr held"}, mem_addr, addr);
        chk({rq, " R10 no early write"}, {30'd0, dst_we, done}, 32'd0);
        @(negedge clk);
      end
      chk({rq, " R10 req"}, 32'(mem_req), 32'd1);
      chk({rq, " R8 addr"}, mem_addr, addr);
      mem_rsp_valid = 1'b1; mem_rsp_data = b;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = 8'h00;
      chk({rq, " R9 dst_we"}, 32'(dst_we), 32'd1);
      chk({rq, " R9 dst_sel"}, 32'(dst_sel), 32'(w[15:12]));
      chk({rq, " R9 dst_data"}, dst_data, {{24{b[7]}}, b});
      chk({rq, " R9 base_we"}, 32'(base_we), 32'(wb));
      if (wb) begin
        chk({rq, " R9 wb_sel"}, 32'(wb_sel), 32'(w[19:16]));
        chk({rq, " R8 wb_data"}, wb_data, off);
      end
      chk({rq, " R9 done load"}, {28'd0, done, outcome}, 32'h8);
      chk({rq, " R10 req dropped"}, 32'(mem_req), 32'd0);
      @(negedge clk);
      chk({rq, " R11 idle after"}, {29'd0, done, dst_we, busy}, 32'd0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h2000_0000 + 32'(i) * 32'h100;
    regs[2] = 32'h0000_0010;
    repeat (3) @(negedge clk);
    chk("R11 reset done", 32'(done), 32'd0);
    chk("R10 reset req", {29'd0, mem_req, dst_we, base_we}, 32'd0);
    rst_n = 1'b1;

    // R10: stray response while idle is ignored
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_data = 8'hAA;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R10 stray rsp", {29'd0, dst_we, done, mem_req}, 32'd0);

    // R1 / R8: fixed form addressing modes
    run("R1 off add",    fx(4'hE, 1, 1, 0, 4'd1, 4'd3, 8'h5A), 0, 1, 0, 8'h7F);
    run("R1 pre sub wb", fx(4'h0, 1, 0, 1, 4'd4, 4'd5, 8'hFF), 0, 1, 2, 8'h80);
    run("R1 post add",   fx(4'h3, 0, 1, 0, 4'd6, 4'd7, 8'h21), 0, 1, 1, 8'hC3);
    run("R8 wrap sub",   fx(4'hE, 1, 0, 1, 4'd2, 4'd8, 8'hFF), 0, 1, 0, 8'h01);
    run("R6 no wb same", fx(4'hE, 1, 1, 0, 4'd9, 4'd9, 8'h04), 0, 1, 0, 8'hF0);
    // R4 / R6 / R5 / R7 on the fixed form
    run("R4 literal",    fx(4'hE, 1, 1, 0, 4'hF, 4'd3, 8'h10), 0, 1, 0, 8'h00);
    run("R4 unpriv",     fx(4'hE, 0, 1, 1, 4'd1, 4'd3, 8'h10), 0, 1, 0, 8'h00);
    run("R6 rt15",       fx(4'hE, 1, 1, 0, 4'd1, 4'hF, 8'h10), 0, 1, 0, 8'h00);
    run("R6 wb same",    fx(4'hE, 0, 1, 0, 4'd5, 4'd5, 8'h10), 0, 1, 0, 8'h00);
    run("R5 cond 1111",  fx(4'hF, 1, 1, 0, 4'd1, 4'd3, 8'h10), 0, 1, 0, 8'h00);
    run("R5 fixed as mixed", fx(4'hE, 1, 1, 0, 4'd1, 4'd3, 8'h10), 1, 1, 0, 8'h00);
    run("R7 cond fail",  fx(4'hE, 1, 1, 1, 4'd1, 4'd3, 8'h10), 0, 0, 0, 8'h00);
    run("R7 after skip", fx(4'hE, 1, 1, 0, 4'd1, 4'd3, 8'h10), 0, 1, 1, 8'h55);
    // R2: first mixed form
    run("R2 imm12",      mx1(4'd3, 4'd4, 12'hFFF), 1, 1, 3, 8'h80);
    run("R2 imm zero",   mx1(4'd3, 4'd3, 12'h000), 1, 1, 0, 8'h7E);
    run("R4 m1 preload", mx1(4'hF, 4'hF, 12'h123), 1, 1, 0, 8'h00);
    run("R4 m1 literal", mx1(4'hF, 4'd2, 12'h123), 1, 1, 0, 8'h00);
    run("R5 mixed as fixed", mx1(4'd3, 4'd4, 12'h001), 0, 1, 0, 8'h00);
    // R3: second mixed form
    run("R3 pre add wb", mx2(4'd1, 4'd2, 1, 1, 1, 8'h40), 1, 1, 1, 8'h90);
    run("R3 post sub wb", mx2(4'd6, 4'd2, 0, 0, 1, 8'h08), 1, 1, 0, 8'h12);
    run("R3 off sub",    mx2(4'd6, 4'd2, 1, 0, 0, 8'hFF), 1, 1, 2, 8'hFF);
    run("R5 m2 undef",   mx2(4'd6, 4'd2, 0, 1, 0, 8'h01), 1, 1, 0, 8'h00);
    run("R4 m2 unpriv",  mx2(4'd6, 4'd2, 1, 1, 0, 8'h01), 1, 1, 0, 8'h00);
    run("R4 m2 preload", mx2(4'hF, 4'hF, 1, 0, 0, 8'h01), 1, 1, 0, 8'h00);
    run("R6 m2 rt15 wb", mx2(4'd6, 4'hF, 1, 1, 1, 8'h01), 1, 1, 0, 8'h00);
    run("R6 m2 wb same", mx2(4'd6, 4'd6, 0, 1, 1, 8'h01), 1, 1, 0, 8'h00);
    run("R7 m2 cond fail", mx2(4'd6, 4'd2, 1, 1, 1, 8'h01), 1, 0, 0, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule